// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches the receive line of an asynchronous serial port and raises a flag when the line has been held low for longer than any legal character could explain. The limit depends on the frame format the port has been set up for, so the block takes the same mode word that sets up the receiver. From that word it works out how many clock cycles make up one complete frame. It then declares a break once the line has stayed low, without a break, for twice that many cycles.

A mode word is captured on a one-cycle load strobe, and the threshold is worked out at that moment. A separate request input acts as the internal reset command: it returns the block to its power-up state, the same as the reset input does. Until a mode word that selects asynchronous operation is loaded, the detector stays idle. The receive input is expected to be already synchronised to the block clock.

Top module: `bd_break_det`

## Requirements
- R1: After reset the break flag `brk_det` is 0, and it stays 0 with the line held low until a mode word is loaded.
- R2: Mode word bits [1:0] give the clocks per bit time: code 01 gives 1, code 10 gives 16, code 11 gives 64.
- R3: Mode word bits [3:2] give the data bit count as 5 plus the code. Bit 4 set adds one parity bit time to the frame.
- R4: Mode word bits [7:6] give the stop time. Code 11 gives two bit times. Code 10 gives one bit time plus half a bit time, with the half rounded down. Codes 01 and 00 give one bit time. Bit 5 is ignored.
- R5: The threshold is twice the sum of one start bit time, the data bit times, the parity bit time and the stop time. `brk_det` goes to 1 right after the threshold-th consecutive clock edge at which `rxd` is sampled low, and not one edge earlier.
- R6: The low-time count stops at the threshold instead of wrapping, and `brk_det` stays 1 for as long as `rxd` is sampled low.
- R7: A clock edge at which `rxd` is sampled high clears the low-time count, so `brk_det` is 0 after that edge. The next low run is counted from zero.
- R8: A mode word with bits [1:0] = 00 (synchronous operation) turns detection off, so `brk_det` stays 0 however long the line is low.
- R9: A `mode_load` edge restarts the low-time count from zero. The new threshold applies from the next edge onward.
- R10: A `clr_req` edge returns the block to its reset state: `brk_det` goes to 0 and detection stays off until the next mode word is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_req | input | 1 | Internal reset command strobe, acts like `rst` |
| mode_load | input | 1 | One-cycle strobe that captures `mode_word` |
| mode_word | input | 8 | Frame format: bits [1:0] baud factor, [3:2] length, [4] parity enable, [7:6] stop code |
| rxd | input | 1 | Receive line, already synchronised to `clk` |
| brk_det | output | 1 | Break detected |

## Verification
The assertions assume that `rxd`, `mode_load` and `clr_req` are clean synchronous levels sampled at the rising edge. They also assume that `rst` is held from time zero until after the first edge, so that the count and the enable are never compared before they have been set. The bench drives every input at the falling edge and holds reset over the first cycles. It returns `rxd` high, or loads a mode word, before each measured low run, so that every run starts from a count of zero. Each run covers the edge just before the threshold, the threshold edge and the edges after it. This holds for the smallest and largest frame formats, for each stop code and for the disabled case.

// File: rtl/bd_pkg.sv
package bd_pkg;

    localparam int MODE_W   = 8;
    localparam int THR_W    = 11;
    localparam int DATA_MIN = 5;
    localparam int BF_X1    = 1;
    localparam int BF_X16   = 16;
    localparam int BF_X64   = 64;

    typedef logic [THR_W-1:0] thr_t;

    typedef enum logic [1:0] {
        BAUD_SYNC = 2'b00,
        BAUD_X1   = 2'b01,
        BAUD_X16  = 2'b10,
        BAUD_X64  = 2'b11
    } baud_e;

    typedef enum logic [1:0] {
        STOP_RSVD     = 2'b00,
        STOP_ONE      = 2'b01,
        STOP_ONE_HALF = 2'b10,
        STOP_TWO      = 2'b11
    } stop_e;

    // field positions are fixed by the receiver that shares this word
    typedef struct packed {
        stop_e       stop;
        logic        spare;
        logic        par_en;
        logic [1:0]  len;
        baud_e       baud;
    } mode_t;

    function automatic thr_t bit_clocks(baud_e b);
        case (b)
            BAUD_X1:  return thr_t'(BF_X1);
            BAUD_X16: return thr_t'(BF_X16);
            BAUD_X64: return thr_t'(BF_X64);
            default:  return '0;
        endcase
    endfunction

    function automatic thr_t stop_clocks(stop_e s, thr_t bc);
        case (s)
            STOP_ONE_HALF: return bc + (bc >> 1);
            STOP_TWO:      return bc << 1;
            default:       return bc;
        endcase
    endfunction

    function automatic thr_t frame_clocks(mode_t m);
        thr_t bc;
        thr_t nbits;
        bc    = bit_clocks(m.baud);
        nbits = thr_t'(DATA_MIN + 1) + thr_t'(m.len) + thr_t'(m.par_en);
        return bc * nbits + stop_clocks(m.stop, bc);
    endfunction

    function automatic thr_t brk_threshold(mode_t m);
        return frame_clocks(m) << 1;
    endfunction

endpackage

// File: rtl/bd_mode_decoder.sv
module bd_mode_decoder
    import bd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_req,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    output logic              en_o,
    output thr_t              thr_o
);

    mode_t mode_in;
    logic  async_sel;
    thr_t  thr_next;

    always_comb begin
        mode_in   = mode_t'(mode_word);
        async_sel = (mode_in.baud != BAUD_SYNC);
        thr_next  = async_sel ? brk_threshold(mode_in) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_req) begin
            en_o  <= 1'b0;
            thr_o <= '0;
        end else if (mode_load) begin
            en_o  <= async_sel;
            thr_o <= thr_next;
        end
    end

endmodule

// File: rtl/bd_low_counter.sv
module bd_low_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             en,
    input  logic             rxd,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst || restart || !en || rxd) begin
            cnt_o <= '0;
        end else if (cnt_o < limit) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bd_break_det.sv
module bd_break_det
    import bd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_req,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              rxd,
    output logic              brk_det
);

    localparam int CNT_W = THR_W;

    logic             en_q;
    thr_t             thr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;

    assign restart = clr_req || mode_load;

    bd_mode_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .clr_req   (clr_req),
        .mode_load (mode_load),
        .mode_word (mode_word),
        .en_o      (en_q),
        .thr_o     (thr_q)
    );

    bd_low_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .en      (en_q),
        .rxd     (rxd),
        .limit   (thr_q),
        .cnt_o   (cnt_q)
    );

    assign brk_det = en_q && (cnt_q == thr_q);

endmodule

// File: rtl/bd_break_det_chk.sv
module bd_break_det_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_req,
    input logic             mode_load,
    input logic             rxd,
    input logic             brk_det,
    input logic             en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thr
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= thr); // R6

    AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        brk_det && !rxd && !mode_load && !clr_req |=> brk_det); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en && !rxd && !mode_load && !clr_req && (cnt < thr)
        |=> cnt == $past(cnt) + CNT_W'(1)); // R5

    AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rxd |=> !brk_det && cnt == '0); // R7

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> !brk_det); // R8

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        mode_load && !clr_req |=> cnt == '0); // R9

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !en && !brk_det); // R10

endmodule

bind bd_break_det bd_break_det_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .clr_req   (clr_req),
    .mode_load (mode_load),
    .rxd       (rxd),
    .brk_det   (brk_det),
    .en        (en_q),
    .cnt       (cnt_q),
    .thr       (thr_q)
);

// File: tb/bd_break_det_tb_top.sv
`timescale 1ns/1ps
module bd_break_det_tb_top;

    localparam int WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_req = 1'b0;
    logic       mode_load = 1'b0;
    logic [7:0] mode_word = 8'h00;
    logic       rxd = 1'b1;
    logic       brk_det;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    bd_break_det dut_i (
        .clk       (clk),
        .rst       (rst),
        .clr_req   (clr_req),
        .mode_load (mode_load),
        .mode_word (mode_word),
        .rxd       (rxd),
        .brk_det   (brk_det)
    );

    // threshold from the frame-format rules of R2, R3, R4 and R5
    function automatic int ref_thr(logic [7:0] m);
        int bc;
        int nb;
        int st;
        bc = (m[1:0] == 2'b01) ? 1 : (m[1:0] == 2'b10) ? 16 : 64;
        nb = 1 + 5 + int'(m[3:2]) + int'(m[4]);
        st = (m[7:6] == 2'b10) ? bc + bc / 2 : (m[7:6] == 2'b11) ? 2 * bc : bc;
        return 2 * (bc * nb + st);
    endfunction

    task automatic drive(input bit r, input bit x, input bit ld, input logic [7:0] m,
                         input bit c, input bit e, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; rxd = x; mode_load = ld; mode_word = m; clr_req = c;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle_high(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(0, 1, 0, 8'h00, 0, 0, tag);
    endtask

    task automatic run_low(input int n, input int thr, input bit en, input string tag);
        for (int i = 1; i <= n; i++) drive(0, 0, 0, 8'h00, 0, en && (i >= thr), tag);
    endtask

    task automatic load(input logic [7:0] m, input bit x, input string tag);
        drive(0, x, 1, m, 0, 0, tag);
    endtask

    // full threshold check: edge before, threshold edge, some edges after, then high
    task automatic check_format(input logic [7:0] m, input string tag);
        int t;
        t = ref_thr(m);
        load(m, 1, tag);
        run_low(t + 3, t, 1, tag);
        idle_high(1, tag);
    endtask

    // monitor
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_run++;
                if (brk_det !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: brk_det=%0b expected %0b at %0t",
                             it.tag, brk_det, it.exp, $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int t;
        // R1: reset state, then low line with no mode loaded
        for (int i = 0; i < 4; i++) drive(1, 0, 0, 8'h00, 0, 0, "R1 in reset");
        run_low(40, 0, 0, "R1 no mode loaded");
        idle_high(2, "R1 idle");

        // R5, R6, R7: x1, 5 bits, no parity, one stop -> 14
        t = ref_thr(8'h41);
        load(8'h41, 1, "R5 load");
        run_low(t + 10, t, 1, "R5 R6 threshold and hold");
        idle_high(1, "R7 high clears");
        run_low(t, t, 1, "R7 restart from zero");
        drive(0, 1, 0, 8'h00, 0, 0, "R7 single high");
        run_low(t - 1, t, 1, "R7 short run");
        idle_high(1, "R7 idle");

        // R3: 8 bits with parity; R4: bit 5 ignored
        check_format(8'h5D, "R3 length 8 parity");
        check_format(8'h7D, "R4 spare bit ignored");
        check_format(8'h49, "R3 length 7 no parity");

        // R4 and R2 stop codes and factors
        check_format(8'h81, "R4 stop 1.5 at x1");
        check_format(8'hC1, "R4 stop 2 at x1");
        check_format(8'h01, "R4 stop code 00");
        check_format(8'h82, "R2 R4 x16 stop 1.5");
        check_format(8'hFF, "R2 x64 largest frame");

        // R8: sync baud code disables detection
        load(8'h4C, 1, "R8 load sync");
        run_low(2000, 0, 0, "R8 sync no break");
        idle_high(1, "R8 idle");

        // R9: reload mid run with a larger threshold
        load(8'h41, 1, "R9 first load");
        run_low(10, ref_thr(8'h41), 1, "R9 partial run");
        t = ref_thr(8'hC1);
        load(8'hC1, 0, "R9 reload while low");
        run_low(t + 2, t, 1, "R9 new threshold");
        idle_high(1, "R9 idle");

        // R10: clear request while in break
        t = ref_thr(8'h41);
        load(8'h41, 1, "R10 load");
        run_low(t + 2, t, 1, "R10 reach break");
        drive(0, 0, 0, 8'h00, 1, 0, "R10 clear");
        run_low(50, t, 0, "R10 disabled after clear");
        check_format(8'h41, "R10 reload works");

        idle_high(3, "end");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule